// File: doc/BRIEF.md
# Serial Register Packet Decoder

This block sits behind a serial byte receiver and turns its byte stream into writes to a small set of configuration registers. The stream is a series of packets sent back to back with nothing between them. Each packet starts with a target identifier byte. A length byte follows, holding the payload size minus one. The payload bytes come last. A frame input marks the stretch of time in which bytes belong to a packet stream. When the frame input drops, the parser forgets any partial packet.

Eight identifiers, starting at a base value, select 32-bit configuration registers. Their payload bytes arrive most significant first. They are gathered in a staging register and copied into the target register only after the final payload byte, together with a one-cycle write strobe. One further identifier selects a byte stream, meant to feed a data FIFO. Each of its payload bytes is passed out with a one-cycle valid and is not stored. For any other identifier the payload is counted and dropped, so the packet after it is still found.

Top module: `cfgpkt_decoder`

## Requirements
- R1: While reset is low and in the first cycle after it, every register value is zero, no write strobe is set and the stream valid is low.
- R2: A packet is an identifier byte, then a length byte L, then exactly L+1 payload bytes. The next accepted byte is taken as the identifier of the following packet, with no separator between packets.
- R3: An identifier from 0x10 to 0x17 targets register index (identifier − 0x10). In the cycle after the last payload byte is accepted, write strobe bit index is high for exactly one cycle, and the register shows its new value in that same cycle. Register values change at no other time.
- R4: A register takes the payload bytes most significant byte first. The new value is the last four payload bytes. A payload shorter than four bytes is zero-extended; for example, 00 00 00 81 gives 0x81, and the single byte 5A gives 0x5A.
- R5: For identifier 0x18, each payload byte appears on the stream byte output with stream valid high for one cycle, in the cycle after that byte is accepted. No register value or write strobe changes.
- R6: For any identifier outside 0x10 to 0x18, the length is still honoured and the payload is dropped without any output activity. The packet after it is decoded normally.
- R7: A byte is accepted only when frame and byte valid are both high. When frame is low, the parser returns to waiting for an identifier. A packet cut off this way gives no strobe and leaves all register values unchanged.
- R8: Cycles with byte valid low are ignored. Idle gaps of any length between or inside packets do not change the decoded result.
- R9: A length byte of 0xFF carries 256 payload bytes.
- R10: At most one write strobe bit is high in any cycle, and a strobe never lasts two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_i | input | 1 | High while a packet stream is in progress |
| byte_vld_i | input | 1 | Byte on byte_i is valid this cycle |
| byte_i | input | 8 | Incoming stream byte |
| reg_we_o | output | NUM_REGS (8) | One-cycle write strobe, one bit per register |
| reg_val_o | output | NUM_REGS*REG_W (256) | Register values, index i at bits [i*REG_W +: REG_W] |
| strm_vld_o | output | 1 | Stream byte valid |
| strm_byte_o | output | 8 | Stream payload byte |

## Verification
The bench sends packets back to back with no idle cycle between them. A design that reads one byte too many or too few would then write the wrong register from that point on. It sends payloads shorter and longer than four bytes, which would show stale upper bytes or a wrong truncation, and a 256-byte stream packet, which a design that misreads the length would misalign. It also cuts a packet short by dropping the frame, sends an unknown identifier whose payload looks like valid identifiers, and spreads bytes out with idle gaps. A design that commits partial data, acts on bytes it should drop, or counts idle cycles would show strobes or values that do not match.

// File: rtl/cfgpkt_pkg.sv
// Shared types for the serial register packet decoder.
// Assumes byte-wide input; all widths derived from BYTE_W.
package cfgpkt_pkg;

    localparam int BYTE_W = 8;

    // Parser position within a packet
    typedef enum logic [1:0] {
        PS_ID   = 2'd0,
        PS_LEN  = 2'd1,
        PS_DATA = 2'd2
    } pstate_t;

    // One accepted payload byte, tagged with its packet identifier
    typedef struct packed {
        logic              vld;
        logic              last;
        logic [BYTE_W-1:0] id;
        logic [BYTE_W-1:0] data;
    } beat_t;

endpackage

// File: rtl/cfgpkt_parser.sv
// Packet framer: tracks identifier / length / payload position in the
// byte stream and emits one tagged beat per accepted payload byte.
// Assumes: a byte is consumed only when frame_i and byte_vld_i are high;
// frame_i low forces the parser back to waiting for an identifier.
module cfgpkt_parser
    import cfgpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              start_o,
    output beat_t             beat_o
);

    pstate_t           state_q;
    logic [BYTE_W-1:0] id_q;
    logic [BYTE_W-1:0] remain_q;
    logic              take;

    assign take = frame_i && byte_vld_i;

    // Packet position, identifier and remaining-byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PS_ID;
            id_q     <= '0;
            remain_q <= '0;
        end else if (!frame_i) begin
            state_q  <= PS_ID;
        end else if (byte_vld_i) begin
            case (state_q)
                PS_ID: begin
                    id_q    <= byte_i;
                    state_q <= PS_LEN;
                end
                PS_LEN: begin
                    remain_q <= byte_i;
                    state_q  <= PS_DATA;
                end
                PS_DATA: begin
                    if (remain_q == '0) begin
                        state_q <= PS_ID;
                    end else begin
                        remain_q <= remain_q - 1'b1;
                    end
                end
                default: state_q <= PS_ID;
            endcase
        end
    end

    // Beat and packet-start outputs for the consumers
    always_comb begin
        start_o     = take && (state_q == PS_ID);
        beat_o.vld  = take && (state_q == PS_DATA);
        beat_o.last = (remain_q == '0);
        beat_o.id   = id_q;
        beat_o.data = byte_i;
    end

endmodule

// File: rtl/cfgpkt_regbank.sv
// Register bank: gathers payload bytes of register packets in a shared
// staging shift register and commits the value, with a one-cycle strobe,
// on the final payload byte. Assumes REG_W is a multiple of BYTE_W and
// greater than BYTE_W; identifiers ID_BASE..ID_BASE+NUM_REGS-1 map here.
module cfgpkt_regbank
    import cfgpkt_pkg::*;
#(
    parameter int unsigned ID_BASE  = 8'h10,
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned REG_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  beat_t                     beat_i,
    output logic [NUM_REGS-1:0]       we_o,
    output logic [NUM_REGS*REG_W-1:0] val_o
);

    localparam int unsigned ID_LAST = ID_BASE + NUM_REGS - 1;
    localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [REG_W-1:0] stage_q;
    logic [REG_W-1:0] stage_next;
    logic             hit;
    logic             commit;
    logic [IDX_W-1:0] idx;
    logic [BYTE_W:0]  id_ext;
    logic [BYTE_W:0]  id_off;

    // Decode the identifier into an in-range flag and a register index
    always_comb begin
        id_ext     = {1'b0, beat_i.id};
        id_off     = id_ext - (BYTE_W+1)'(ID_BASE);
        hit        = (32'(beat_i.id) >= ID_BASE) && (32'(beat_i.id) <= ID_LAST);
        idx        = id_off[IDX_W-1:0];
        commit     = beat_i.vld && beat_i.last && hit;
        stage_next = {stage_q[REG_W-BYTE_W-1:0], beat_i.data};
    end

    // Staging shift register, cleared at every packet start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (start_i) begin
            stage_q <= '0;
        end else if (beat_i.vld && hit) begin
            stage_q <= stage_next;
        end
    end

    // One committed register and strobe per identifier
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [REG_W-1:0] val_q;
        logic             we_q;

        // Commit on the last payload byte for this index
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                we_q  <= 1'b0;
            end else begin
                we_q <= commit && (idx == IDX_W'(g));
                if (commit && (idx == IDX_W'(g))) begin
                    val_q <= stage_next;
                end
            end
        end

        assign we_o[g]                   = we_q;
        assign val_o[g*REG_W +: REG_W]   = val_q;
    end

endmodule

// File: rtl/cfgpkt_stream.sv
// Stream port: forwards each payload byte of the stream identifier as a
// registered byte with a one-cycle valid. Nothing is stored beyond one beat.
module cfgpkt_stream
    import cfgpkt_pkg::*;
#(
    parameter int unsigned STREAM_ID = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  beat_t             beat_i,
    output logic              vld_o,
    output logic [BYTE_W-1:0] byte_o
);

    logic              vld_q;
    logic [BYTE_W-1:0] byte_q;

    // Register the stream beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            byte_q <= '0;
        end else begin
            vld_q <= beat_i.vld && (beat_i.id == BYTE_W'(STREAM_ID));
            if (beat_i.vld && (beat_i.id == BYTE_W'(STREAM_ID))) begin
                byte_q <= beat_i.data;
            end
        end
    end

    assign vld_o  = vld_q;
    assign byte_o = byte_q;

endmodule

// File: rtl/cfgpkt_decoder.sv
// Top: serial register packet decoder. Splits a back-to-back packet
// stream (id, length-1, payload) into register writes and a byte stream.
// Assumes one byte per cycle at most; outputs are registered (1 cycle).
module cfgpkt_decoder
    import cfgpkt_pkg::*;
#(
    parameter int unsigned ID_BASE   = 8'h10,
    parameter int unsigned NUM_REGS  = 8,
    parameter int unsigned REG_W     = 32,
    parameter int unsigned STREAM_ID = 8'h18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_i,
    input  logic                      byte_vld_i,
    input  logic [7:0]                byte_i,
    output logic [NUM_REGS-1:0]       reg_we_o,
    output logic [NUM_REGS*REG_W-1:0] reg_val_o,
    output logic                      strm_vld_o,
    output logic [7:0]                strm_byte_o
);

    logic  start;
    beat_t beat;

    cfgpkt_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_i    (frame_i),
        .byte_vld_i (byte_vld_i),
        .byte_i     (byte_i),
        .start_o    (start),
        .beat_o     (beat)
    );

    cfgpkt_regbank #(
        .ID_BASE  (ID_BASE),
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .beat_i  (beat),
        .we_o    (reg_we_o),
        .val_o   (reg_val_o)
    );

    cfgpkt_stream #(
        .STREAM_ID (STREAM_ID)
    ) u_stream (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (beat),
        .vld_o  (strm_vld_o),
        .byte_o (strm_byte_o)
    );

endmodule

// File: rtl/cfgpkt_decoder_checks.sv
// Port-level properties of the packet decoder, bound to the top module.
module cfgpkt_decoder_checks #(
    parameter int unsigned NUM_REGS = 8,
    parameter int unsigned REG_W    = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_i,
    input logic                      byte_vld_i,
    input logic [NUM_REGS-1:0]       reg_we_o,
    input logic [NUM_REGS*REG_W-1:0] reg_val_o,
    input logic                      strm_vld_o
);

    // R1: registers come out of reset cleared and quiet
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (reg_val_o == '0 && reg_we_o == '0 && !strm_vld_o));

    // R10: at most one strobe bit at a time
    assert_we_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_we_o));

    // R10: a strobe lasts a single cycle
    assert_we_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_o != '0) |=> (reg_we_o == '0));

    // R3: register values change only together with a strobe
    assert_val_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_val_o) |-> (reg_we_o != '0));

    // R5: stream output and register strobes never coincide
    assert_stream_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(strm_vld_o && (reg_we_o != '0)));

    // R7: no output follows a cycle with frame low
    assert_frame_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> (reg_we_o == '0 && !strm_vld_o));

    // R8: no output follows a cycle without a valid byte
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld_i |=> (reg_we_o == '0 && !strm_vld_o));

endmodule

bind cfgpkt_decoder cfgpkt_decoder_checks #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .byte_vld_i (byte_vld_i),
    .reg_we_o   (reg_we_o),
    .reg_val_o  (reg_val_o),
    .strm_vld_o (strm_vld_o)
);

// File: tb/test_cfgpkt_decoder.sv
// Directed bench for the packet decoder: one task per scenario.
module test_cfgpkt_decoder;

    localparam int NREG = 8;
    localparam int RW   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_i = 1'b0;
    logic              byte_vld_i = 1'b0;
    logic [7:0]        byte_i = '0;
    logic [NREG-1:0]   reg_we_o;
    logic [NREG*RW-1:0] reg_val_o;
    logic              strm_vld_o;
    logic [7:0]        strm_byte_o;

    cfgpkt_decoder i_cfgpkt_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_i     (frame_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .reg_we_o    (reg_we_o),
        .reg_val_o   (reg_val_o),
        .strm_vld_o  (strm_vld_o),
        .strm_byte_o (strm_byte_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // expectation model
    logic [RW-1:0] exp_val [NREG];
    int            exp_cnt [NREG];
    logic [7:0]    exp_strm [0:511];
    int            exp_strm_n = 0;
    logic [7:0]    pl [0:299];

    // observed activity
    int            we_cnt [NREG];
    logic [7:0]    got_strm [0:511];
    int            got_strm_n = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor samples outputs away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NREG; i++) if (reg_we_o[i]) we_cnt[i]++;
            if (strm_vld_o) begin
                got_strm[got_strm_n] = strm_byte_o;
                got_strm_n++;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic put(input logic [7:0] b);
        byte_vld_i = 1'b1;
        byte_i     = b;
        @(negedge clk);
        byte_vld_i = 1'b0;
    endtask

    task automatic idle(input int n);
        byte_vld_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // send id, n-1, pl[0..n-1]; gap idle cycles after each byte; update model
    task automatic send_pkt(input logic [7:0] id, input int n, input int gap);
        logic [RW-1:0] v;
        put(id);
        if (gap > 0) idle(gap);
        put(8'(n - 1));
        if (gap > 0) idle(gap);
        v = '0;
        for (int k = 0; k < n; k++) begin
            put(pl[k]);
            if (gap > 0) idle(gap);
            v = {v[RW-9:0], pl[k]};
            if (id == 8'h18) begin
                exp_strm[exp_strm_n] = pl[k];
                exp_strm_n++;
            end
        end
        if (id >= 8'h10 && id <= 8'h17) begin
            exp_val[id - 8'h10] = v;
            exp_cnt[id - 8'h10]++;
        end
    endtask

    task automatic check_all(input string tag);
        idle(2);
        for (int i = 0; i < NREG; i++) begin
            check(reg_val_o[i*RW +: RW] == exp_val[i], $sformatf("%s value reg%0d", tag, i),
                  64'(reg_val_o[i*RW +: RW]), 64'(exp_val[i]));
            check(we_cnt[i] == exp_cnt[i], $sformatf("%s strobes reg%0d", tag, i),
                  64'(we_cnt[i]), 64'(exp_cnt[i]));
        end
        check(got_strm_n == exp_strm_n, {tag, " stream count"}, 64'(got_strm_n), 64'(exp_strm_n));
        for (int k = 0; k < exp_strm_n && k < got_strm_n; k++)
            check(got_strm[k] == exp_strm[k], $sformatf("%s stream byte %0d", tag, k),
                  64'(got_strm[k]), 64'(exp_strm[k]));
    endtask

    task automatic t_reset;
        check(reg_val_o == '0, "R1 values zero", 64'(reg_val_o[63:0]), 64'h0);
        check(reg_we_o == '0, "R1 no strobe", 64'(reg_we_o), 64'h0);
        check(strm_vld_o == 1'b0, "R1 no stream", 64'(strm_vld_o), 64'h0);
    endtask

    // R3 R10: strobe timing on a 4-byte write to index 6
    task automatic t_timing;
        pl[0] = 8'h12; pl[1] = 8'h34; pl[2] = 8'h56;
        put(8'h16); put(8'h03); put(8'h12); put(8'h34); put(8'h56);
        check(reg_we_o == '0, "R3 no strobe before last byte", 64'(reg_we_o), 64'h0);
        put(8'h78);
        check(reg_we_o == 8'h40, "R3 strobe after last byte", 64'(reg_we_o), 64'h40);
        check(reg_val_o[6*RW +: RW] == 32'h12345678, "R3 value with strobe",
              64'(reg_val_o[6*RW +: RW]), 64'h12345678);
        idle(1);
        check(reg_we_o == '0, "R10 strobe one cycle", 64'(reg_we_o), 64'h0);
        exp_val[6] = 32'h12345678;
        exp_cnt[6]++;
        check_all("R3");
    endtask

    // R4: short and long payloads
    task automatic t_widths;
        pl[0] = 8'h5A;
        send_pkt(8'h13, 1, 0);
        check_all("R4 short");
        for (int k = 0; k < 6; k++) pl[k] = 8'(k + 1);
        send_pkt(8'h10, 6, 0);
        check_all("R4 long");
        check(reg_val_o[0 +: RW] == 32'h03040506, "R4 keeps last four",
              64'(reg_val_o[0 +: RW]), 64'h03040506);
    endtask

    // R2: packets back to back with no gaps
    task automatic t_back_to_back;
        pl[0] = 8'hAA; pl[1] = 8'hBB; pl[2] = 8'hCC;
        send_pkt(8'h11, 3, 0);
        pl[0] = 8'h01; pl[1] = 8'h02;
        send_pkt(8'h12, 2, 0);
        pl[0] = 8'h00; pl[1] = 8'h00; pl[2] = 8'h00; pl[3] = 8'h81;
        send_pkt(8'h17, 4, 0);
        check_all("R2");
        check(reg_val_o[7*RW +: RW] == 32'h81, "R4 msb first", 64'(reg_val_o[7*RW +: RW]), 64'h81);
    endtask

    // R5 R9: stream packets, including a full 256-byte one
    task automatic t_stream;
        for (int k = 0; k < 5; k++) pl[k] = 8'(8'hE0 + k);
        send_pkt(8'h18, 5, 0);
        check_all("R5");
        for (int k = 0; k < 256; k++) pl[k] = 8'(k * 7 + 3);
        send_pkt(8'h18, 256, 0);
        pl[0] = 8'h99;
        send_pkt(8'h15, 1, 0);
        check_all("R9");
    endtask

    // R6: unknown identifier with payload that looks like identifiers
    task automatic t_unknown;
        pl[0] = 8'h16; pl[1] = 8'h00; pl[2] = 8'h18;
        send_pkt(8'h40, 3, 0);
        pl[0] = 8'h0F; pl[1] = 8'hED;
        send_pkt(8'h14, 2, 0);
        check_all("R6");
    endtask

    // R8: idle gaps inside and between packets
    task automatic t_gaps;
        pl[0] = 8'hC0; pl[1] = 8'hFF; pl[2] = 8'hEE;
        send_pkt(8'h12, 3, 2);
        idle(3);
        pl[0] = 8'h71;
        send_pkt(8'h18, 1, 1);
        check_all("R8");
    endtask

    // R7: frame drop mid-packet
    task automatic t_abort;
        put(8'h15); put(8'h03); put(8'hDE); put(8'hAD);
        frame_i = 1'b0;
        put(8'hBE);
        frame_i = 1'b1;
        check_all("R7 abort");
        pl[0] = 8'h34; pl[1] = 8'h21;
        send_pkt(8'h15, 2, 0);
        check_all("R7 recover");
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            exp_val[i] = '0;
            exp_cnt[i] = 0;
            we_cnt[i]  = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        frame_i = 1'b1;
        t_timing();
        t_widths();
        t_back_to_back();
        t_stream();
        t_unknown();
        t_gaps();
        t_abort();
        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule